// File: doc/BRIEF.md
# Rotating Palette Colour Mapper

This block turns an escape-time iteration count from a fractal engine into a 12-bit RGB pixel colour. The colours come from a 64-entry palette. Each palette entry is held as one packed word in a small ROM, and the three 4-bit channels are taken out of that word with shifts and masks. Before the lookup, a rotation offset is added to the count. The offset steps forward after a fixed number of frame ticks, so the image colours appear to cycle through the palette.

Each time the offset changes, the block raises a one-cycle recompute request so that the upstream engine redraws the whole frame. Points that hit the iteration limit are treated as inside the set and are always shown as black. The count is looked up through a single register stage, so the colour for a count appears one clock after the count is presented.

Top module: `palette_rotator`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `red`, `green` and `blue` are 0 and `recompute_req` is 0. The rotation offset restarts at 0.
- R2: Palette entry i (0..63) is a 12-bit word. Its R field sits in bits 11:8 and equals i>>2. Its G field sits in bits 7:4 and equals (3*i) mod 16. Its B field sits in bits 3:0 and equals 15-(i mod 16). The three output channels show these fields.
- R3: The palette index is (iter_count + offset) mod 64.
- R4: A count greater than or equal to ITER_LIMIT (default 200) gives black (0,0,0), whatever the offset.
- R5: The colour for a count presented before a rising edge appears on the outputs after that edge and stays until the next edge. That is one cycle of latency.
- R6: The offset rises by exactly one on the edge that samples the TICKS_PER_STEP-th `frame_tick` since the last step (default 3). Cycles without a tick leave it unchanged.
- R7: `recompute_req` is high for exactly the cycles in which a new offset value first takes effect, and is low otherwise.
- R8: The offset wraps from 63 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iter_count | input | 8 | Escape-time iteration count of the current pixel |
| frame_tick | input | 1 | One-cycle pulse per displayed frame |
| red | output | 4 | Red channel |
| green | output | 4 | Green channel |
| blue | output | 4 | Blue channel |
| recompute_req | output | 1 | One-cycle request to redraw the frame after a palette step |

## Verification
The assertions take `rst` to be synchronous and the inputs to be stable around each rising edge. They place no limit on how often `frame_tick` pulses, since a tick on every cycle is legal. The stimulus changes inputs only on falling edges. It mixes sparse ticks, back-to-back ticks and long stretches with no tick, and drives counts that are sequential, random, exactly at the limit and above it. The run lasts long enough for the offset to wrap more than once.

// File: rtl/palrot_pkg.sv
package palrot_pkg;
  localparam int CH_W   = 4;
  localparam int WORD_W = 3 * CH_W;
  localparam int R_LSB  = 2 * CH_W;
  localparam int G_LSB  = CH_W;
  localparam int B_LSB  = 0;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  // Packed palette word for entry idx.
  function automatic logic [WORD_W-1:0] pal_word(input int idx);
    logic [CH_W-1:0] r, g, b;
    r = CH_W'(idx >> 2);
    g = CH_W'((3 * idx) % 16);
    b = CH_W'(15 - (idx % 16));
    return {r, g, b};
  endfunction
endpackage

// File: rtl/palrot_rom.sv
module palrot_rom #(
  parameter int PAL_W = 6
) (
  input  logic                         clk,
  input  logic [PAL_W-1:0]             addr,
  output logic [palrot_pkg::WORD_W-1:0] word_q
);
  import palrot_pkg::*;
  localparam int DEPTH = 1 << PAL_W;

  logic [WORD_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = pal_word(i);
  end

  // Registered read, block-RAM friendly.
  always_ff @(posedge clk) word_q <= mem[addr];
endmodule

// File: rtl/palrot_rotor.sv
module palrot_rotor #(
  parameter int PAL_W          = 6,
  parameter int TICKS_PER_STEP = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_tick,
  output logic [PAL_W-1:0] offset,
  output logic             step_pulse
);
  localparam int TCW = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
  localparam logic [TCW-1:0] TLAST = TCW'(TICKS_PER_STEP - 1);

  logic [TCW-1:0] tick_cnt;
  logic           step_now;

  assign step_now = frame_tick && (tick_cnt == TLAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt   <= '0;
      offset     <= '0;
      step_pulse <= 1'b0;
    end else begin
      step_pulse <= step_now;
      if (frame_tick) begin
        if (step_now) begin
          tick_cnt <= '0;
          offset   <= offset + 1'b1;
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(offset)); // R6
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (offset != $past(offset)) |-> (offset == $past(offset) + 1'b1)); // R6
  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    step_pulse |-> (offset != $past(offset))); // R7
  AST_CHANGE_HAS_PULSE: assert property (@(posedge clk) disable iff (rst)
    (offset != $past(offset)) |-> step_pulse); // R7
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (step_pulse && ($past(offset) == {PAL_W{1'b1}})) |-> (offset == '0)); // R8
endmodule

// File: rtl/palrot_unpack.sv
module palrot_unpack (
  input  logic [palrot_pkg::WORD_W-1:0] word,
  input  logic                          black,
  output palrot_pkg::rgb_t              pix
);
  import palrot_pkg::*;
  localparam logic [WORD_W-1:0] MASK = WORD_W'((1 << CH_W) - 1);

  logic [WORD_W-1:0] r_f, g_f, b_f;
  assign r_f = (word >> R_LSB) & MASK;
  assign g_f = (word >> G_LSB) & MASK;
  assign b_f = (word >> B_LSB) & MASK;

  always_comb begin
    if (black) pix = '0;
    else begin
      pix.r = r_f[CH_W-1:0];
      pix.g = g_f[CH_W-1:0];
      pix.b = b_f[CH_W-1:0];
    end
  end
endmodule

// File: rtl/palette_rotator.sv
module palette_rotator #(
  parameter int CNT_W          = 8,
  parameter int ITER_LIMIT     = 200,
  parameter int PAL_W          = 6,
  parameter int TICKS_PER_STEP = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] iter_count,
  input  logic             frame_tick,
  output logic [3:0]       red,
  output logic [3:0]       green,
  output logic [3:0]       blue,
  output logic             recompute_req
);
  import palrot_pkg::*;

  logic [PAL_W-1:0]  offset;
  logic [PAL_W-1:0]  idx;
  logic [WORD_W-1:0] word_q;
  logic              black_q;
  rgb_t              pix;

  palrot_rotor #(.PAL_W(PAL_W), .TICKS_PER_STEP(TICKS_PER_STEP)) u_rotor (
    .clk(clk), .rst(rst), .frame_tick(frame_tick),
    .offset(offset), .step_pulse(recompute_req));

  assign idx = iter_count[PAL_W-1:0] + offset;

  palrot_rom #(.PAL_W(PAL_W)) u_rom (.clk(clk), .addr(idx), .word_q(word_q));

  always_ff @(posedge clk) begin
    if (rst) black_q <= 1'b1;
    else     black_q <= (32'(iter_count) >= ITER_LIMIT);
  end

  palrot_unpack u_unpack (.word(word_q), .black(black_q), .pix(pix));

  assign red   = pix.r;
  assign green = pix.g;
  assign blue  = pix.b;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> ({red, green, blue} == '0 && !recompute_req)); // R1
  AST_LIMIT_BLACK: assert property (@(posedge clk) disable iff (rst)
    (32'(iter_count) >= ITER_LIMIT) |=> ({red, green, blue} == '0)); // R4
  AST_BLUE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (32'(iter_count) < ITER_LIMIT && (idx[3:0] != 4'hF)) |=> (blue != 4'h0)); // R5
endmodule

// File: tb/palette_rotator_tb.sv
module palette_rotator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 200;
  localparam int P = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] iter_count = '0;
  logic frame_tick = 1'b0;
  logic [3:0] red, green, blue;
  logic recompute_req;

  int errors = 0;
  int checks = 0;
  int m_off = 0, m_tc = 0;
  int e_r = 0, e_g = 0, e_b = 0, e_req = 0;
  int steps_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  palette_rotator u_dut (.clk(clk), .rst(rst), .iter_count(iter_count),
    .frame_tick(frame_tick), .red(red), .green(green), .blue(blue),
    .recompute_req(recompute_req));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge: check the outputs, then drive new inputs and
  // predict the state after the next rising edge.
  task automatic cycle(int cnt, bit tick);
    int i;
    chk("R2/R3/R5 red", red, e_r);
    chk("R2/R3/R5 green", green, e_g);
    chk("R2/R3/R5 blue", blue, e_b);
    chk("R7 recompute_req", recompute_req, e_req);
    iter_count = 8'(cnt);
    frame_tick = tick;
    i = (cnt + m_off) % 64;
    if (cnt >= LIMIT) begin e_r = 0; e_g = 0; e_b = 0; end // R4
    else begin e_r = i / 4; e_g = (3 * i) % 16; e_b = 15 - (i % 16); end
    e_req = 0;
    if (tick) begin
      if (m_tc == P - 1) begin
        m_tc = 0; m_off = (m_off + 1) % 64; e_req = 1; steps_seen++; // R6 R8
      end else m_tc++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 red", red, 0); chk("R1 green", green, 0); chk("R1 blue", blue, 0);
    chk("R1 recompute_req", recompute_req, 0);
    rst = 1'b0;
    e_r = 0; e_g = 0; e_b = 0; e_req = 0;
    // R1: offset starts at 0 -> identity index; R2 R3 sequential sweep
    for (int c = 0; c < 64; c++) cycle(c, 0);
    // R4: exactly at and above the limit
    cycle(LIMIT, 0); cycle(LIMIT - 1, 0); cycle(255, 0); cycle(LIMIT + 1, 0);
    // R6: sparse ticks
    for (int k = 0; k < 40; k++) cycle(k * 7 % 256, (k % 4) == 0);
    // R6 R7: back-to-back ticks
    for (int k = 0; k < 30; k++) cycle($urandom_range(0, 255), 1);
    // R6: long quiet stretch, offset must hold
    for (int k = 0; k < 50; k++) cycle(k, 0);
    // R8: rotate through at least two wraps with random counts
    for (int k = 0; k < 500; k++) cycle($urandom_range(0, 210), ($urandom_range(0, 1) == 1));
    for (int k = 0; k < 120; k++) cycle(k % 64, 1);
    cycle(0, 0); cycle(0, 0);
    checks++;
    if (steps_seen < 130) begin
      errors++;
      $display("FAIL R8 steps actual=%0d expected>=130", steps_seen);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule